// File: doc/BRIEF.md
# Bytecode ALU Execute Unit

This unit carries out the arithmetic and logic instructions of a 64-bit register-machine bytecode. The 8-bit opcode, the 16-bit offset field, the 32-bit immediate and the two 64-bit register operands are presented with a one-cycle `start` pulse. The unit returns a registered 64-bit result, a `done` pulse, a write-enable for the destination register and an illegal-instruction flag. The register file, fetch, memory and branching are handled elsewhere.

Two instruction classes are handled: one computes on all 64 bits and one on the low 32 bits, with the 32-bit result zero-extended. The offset field also works as a sub-opcode. On a move it selects sign extension of 8, 16 or 32 source bits. On divide and modulo it selects signed arithmetic. A byte-swap operation reverses the bytes of the low 16, 32 or 64 bits of the destination, selected by the immediate.

Divide and modulo use an iterative one-bit-per-cycle engine. All other operations finish in a single cycle. A `start` that arrives while a divide is in flight is ignored.

Top module: `bcalu_unit`

## Requirements
- R1: The opcode is split as {code[7:4], source[3], class[2:0]}. Class 3'h7 computes on 64 bits and class 3'h4 on 32 bits. Any other class is illegal. Source 1 takes `src_val`. Source 0 takes the immediate, sign-extended to 64 bits.
- R2: With offset 0, code 0x0 adds, 0x1 subtracts (dst minus src), 0x2 multiplies (low bits kept), 0x4 ORs, 0x5 ANDs and 0xa XORs the destination with the source.
- R3: Code 0x6 shifts left, 0x7 shifts right logically and 0xc shifts right arithmetically. The shift amount is the source masked to 6 bits in the 64-bit class and to 5 bits in the 32-bit class.
- R4: Every legal 32-bit-class result has bits 63:32 equal to zero.
- R5: Code 0xb (move) with offset 0 copies the source. With source 1 and offset 8, 16 or 32 in the 64-bit class, it sign-extends the low 8, 16 or 32 bits of `src_val` to 64 bits.
- R6: In the 32-bit class, a move with source 1 and offset 8 or 16 sign-extends to 32 bits and then zero-extends to 64. Offset 32 is illegal in this class.
- R7: Codes 0x3 (quotient) and 0x9 (remainder) are unsigned with offset 0 and signed with offset 1. Signed quotients truncate toward zero, and the remainder takes the sign of the dividend. Other offsets are illegal.
- R8: A zero divisor gives quotient 0, and the remainder equals the dividend (its low 32 bits in the 32-bit class).
- R9: A signed divide of the most negative value by -1 returns the most negative value, and the matching remainder is 0, in both classes.
- R10: Code 0xd in the 64-bit class with source 0 and offset 0 swaps bytes. Immediate 0x10, 0x20 or 0x40 reverses the bytes of the low 16, 32 or 64 bits of `dst_val`, and the bits above the swapped width are cleared. Any other immediate, source 1, or the 32-bit class is illegal.
- R11: Code 0x8 negates `dst_val` and requires source 0 and offset 0.
- R12: An illegal combination raises `illegal` with `done`, keeps `wr_en` low and returns result 0. This includes codes 0xe and 0xf, and a non-zero offset on any code other than move, quotient and remainder.
- R13: `done` rises one cycle after `start` for non-divide and illegal requests. For a divide it rises 66 cycles after `start` with a non-zero divisor and 2 cycles after with a zero divisor. A `start` while a divide is busy is ignored. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, ignored while a divide runs |
| opcode | input | 8 | {code, source, class} |
| offset | input | 16 | Sub-opcode for move and divide |
| imm | input | 32 | Immediate operand / swap width |
| dst_val | input | 64 | Destination register operand |
| src_val | input | 64 | Source register operand |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Value to write to the destination |
| wr_en | output | 1 | Destination write enable, only with done |
| illegal | output | 1 | Illegal-instruction flag, only with done |

## Verification
The bench sweeps all 256 opcodes against several offsets, immediates and operand pairs. Among the pairs are the most negative value against -1, a zero divisor, and a value whose high word is non-zero but whose low word is zero. A design that divides naively would trap or wrap on the overflow pair, or return garbage on the zero divisor. A design that tests the whole 64-bit divisor in the 32-bit class would miss the zero divisor hidden in the low word. A design that sign-extends 32-bit results would leak ones into the upper word. Directed cases cover byte swaps of each width with cleared upper bits, unlisted swap widths, and a request held during a divide, which a design without a busy guard would accept and then corrupt.

// File: rtl/bcalu_pkg.sv
package bcalu_pkg;
    localparam int XLEN  = 64;
    localparam int HALF  = XLEN / 2;
    localparam int IMM_W = 32;

    localparam logic [2:0] CLS_W32 = 3'h4;
    localparam logic [2:0] CLS_W64 = 3'h7;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0, OP_SUB  = 4'h1, OP_MUL  = 4'h2, OP_DIV  = 4'h3,
        OP_OR   = 4'h4, OP_AND  = 4'h5, OP_LSH  = 4'h6, OP_RSH  = 4'h7,
        OP_NEG  = 4'h8, OP_MOD  = 4'h9, OP_XOR  = 4'ha, OP_MOV  = 4'hb,
        OP_ARSH = 4'hc, OP_SWAP = 4'hd, OP_RSVE = 4'he, OP_RSVF = 4'hf
    } alu_op_e;

    typedef enum logic [1:0] {EXT_NONE, EXT_B, EXT_H, EXT_W} sext_e;
    typedef enum logic [1:0] {SWP_16, SWP_32, SWP_64} swap_e;

    typedef struct packed {
        logic    legal;
        logic    wide;
        logic    use_reg;
        alu_op_e op;
        logic    is_div;
        logic    signed_div;
        logic    want_rem;
        sext_e   ext;
        swap_e   swp;
    } dec_t;
endpackage

// File: rtl/bcalu_decode.sv
module bcalu_decode
    import bcalu_pkg::*;
(
    input  logic [7:0]       opcode,
    input  logic [15:0]      offset,
    input  logic [IMM_W-1:0] imm,
    output dec_t             dec_o
);
    logic    cls_ok;
    logic    off_zero;
    logic    ok;
    alu_op_e op;

    always_comb begin
        dec_o    = '0;
        op       = alu_op_e'(opcode[7:4]);
        cls_ok   = (opcode[2:0] == CLS_W64) || (opcode[2:0] == CLS_W32);
        off_zero = (offset == 16'd0);
        ok       = 1'b0;
        dec_o.op      = op;
        dec_o.use_reg = opcode[3];
        dec_o.wide    = (opcode[2:0] == CLS_W64);
        dec_o.ext     = EXT_NONE;
        dec_o.swp     = SWP_64;
        case (op)
            OP_ADD, OP_SUB, OP_MUL, OP_OR, OP_AND,
            OP_LSH, OP_RSH, OP_XOR, OP_ARSH: ok = off_zero;
            OP_NEG: ok = off_zero && !opcode[3];
            OP_DIV, OP_MOD: begin
                ok               = (offset[15:1] == 15'd0);
                dec_o.is_div     = 1'b1;
                dec_o.signed_div = offset[0];
                dec_o.want_rem   = (op == OP_MOD);
            end
            OP_MOV: begin
                if (off_zero) begin
                    ok = 1'b1;
                end else if (opcode[3]) begin
                    case (offset)
                        16'd8:  begin ok = 1'b1;       dec_o.ext = EXT_B; end
                        16'd16: begin ok = 1'b1;       dec_o.ext = EXT_H; end
                        16'd32: begin ok = dec_o.wide; dec_o.ext = EXT_W; end
                        default: ok = 1'b0;
                    endcase
                end
            end
            OP_SWAP: begin
                case (imm)
                    32'h10:  begin ok = 1'b1; dec_o.swp = SWP_16; end
                    32'h20:  begin ok = 1'b1; dec_o.swp = SWP_32; end
                    32'h40:  begin ok = 1'b1; dec_o.swp = SWP_64; end
                    default: ok = 1'b0;
                endcase
                ok = ok && dec_o.wide && !opcode[3] && off_zero;
            end
            default: ok = 1'b0;
        endcase
        dec_o.legal = cls_ok && ok;
    end
endmodule

// File: rtl/bcalu_exec.sv
module bcalu_exec
    import bcalu_pkg::*;
(
    input  alu_op_e          op,
    input  logic             wide,
    input  logic             use_reg,
    input  sext_e            ext,
    input  swap_e            swp,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    output logic [XLEN-1:0]  result
);
    localparam int NBYTE = XLEN / 8;
    localparam int SH64  = $clog2(XLEN);
    localparam int SH32  = $clog2(HALF);

    logic [XLEN-1:0] s;
    logic [HALF-1:0] a32, b32;
    logic [XLEN-1:0] r64;
    logic [HALF-1:0] r32;
    logic [XLEN-1:0] rev64;
    logic [HALF-1:0] rev32;
    logic [15:0]     rev16;

    assign s   = use_reg ? src_val : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
    assign a32 = dst_val[HALF-1:0];
    assign b32 = s[HALF-1:0];

    for (genvar g = 0; g < NBYTE; g++) begin : g_rev64
        assign rev64[8*g +: 8] = dst_val[8*(NBYTE-1-g) +: 8];
    end
    for (genvar g = 0; g < NBYTE/2; g++) begin : g_rev32
        assign rev32[8*g +: 8] = dst_val[8*(NBYTE/2-1-g) +: 8];
    end
    assign rev16 = {dst_val[7:0], dst_val[15:8]};

    always_comb begin
        r64 = '0;
        r32 = '0;
        case (op)
            OP_ADD:  begin r64 = dst_val + s; r32 = a32 + b32; end
            OP_SUB:  begin r64 = dst_val - s; r32 = a32 - b32; end
            OP_MUL:  begin r64 = dst_val * s; r32 = a32 * b32; end
            OP_OR:   begin r64 = dst_val | s; r32 = a32 | b32; end
            OP_AND:  begin r64 = dst_val & s; r32 = a32 & b32; end
            OP_XOR:  begin r64 = dst_val ^ s; r32 = a32 ^ b32; end
            OP_LSH:  begin r64 = dst_val << s[SH64-1:0]; r32 = a32 << b32[SH32-1:0]; end
            OP_RSH:  begin r64 = dst_val >> s[SH64-1:0]; r32 = a32 >> b32[SH32-1:0]; end
            OP_ARSH: begin
                r64 = $signed(dst_val) >>> s[SH64-1:0];
                r32 = $signed(a32) >>> b32[SH32-1:0];
            end
            OP_NEG:  begin r64 = -dst_val; r32 = -a32; end
            OP_MOV: begin
                case (ext)
                    EXT_B:   begin r64 = {{(XLEN-8){s[7]}}, s[7:0]};
                                   r32 = {{(HALF-8){s[7]}}, s[7:0]}; end
                    EXT_H:   begin r64 = {{(XLEN-16){s[15]}}, s[15:0]};
                                   r32 = {{(HALF-16){s[15]}}, s[15:0]}; end
                    EXT_W:   begin r64 = {{(XLEN-HALF){s[HALF-1]}}, s[HALF-1:0]};
                                   r32 = b32; end
                    default: begin r64 = s; r32 = b32; end
                endcase
            end
            OP_SWAP: begin
                case (swp)
                    SWP_16:  r64 = {{(XLEN-16){1'b0}}, rev16};
                    SWP_32:  r64 = {{(XLEN-HALF){1'b0}}, rev32};
                    default: r64 = rev64;
                endcase
            end
            default: begin r64 = '0; r32 = '0; end
        endcase
        result = wide ? r64 : {{(XLEN-HALF){1'b0}}, r32};
    end
endmodule

// File: rtl/bcalu_divider.sv
module bcalu_divider
    import bcalu_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         sgn,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CNT_W = $clog2(W) + 1;

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     part;
        logic [W-1:0]     qacc;
        logic [W-1:0]     dvs;
        logic             neg_q;
        logic             neg_r;
        logic             sgn;
        logic [W-1:0]     a_in;
        logic [W-1:0]     b_in;
        logic             done;
        logic [W-1:0]     q_out;
        logic [W-1:0]     r_out;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [W-1:0] a_mag, b_mag;
    logic [W:0]   trial, diff;
    logic [W-1:0] part_nx, qacc_nx;

    always_comb begin
        a_mag   = (sgn && dividend[W-1]) ? -dividend : dividend;
        b_mag   = (sgn && divisor[W-1])  ? -divisor  : divisor;
        trial   = {st_q.part, st_q.qacc[W-1]};
        diff    = trial - {1'b0, st_q.dvs};
        if (!diff[W]) begin
            part_nx = diff[W-1:0];
            qacc_nx = {st_q.qacc[W-2:0], 1'b1};
        end else begin
            part_nx = trial[W-1:0];
            qacc_nx = {st_q.qacc[W-2:0], 1'b0};
        end

        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.neg_q = sgn && (dividend[W-1] ^ divisor[W-1]);
            st_d.neg_r = sgn && dividend[W-1];
            st_d.sgn   = sgn;
            st_d.a_in  = dividend;
            st_d.b_in  = divisor;
            if (divisor == '0) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.q_out = '0;
                st_d.r_out = dividend;
            end else begin
                st_d.busy = 1'b1;
                st_d.cnt  = '0;
                st_d.part = '0;
                st_d.qacc = a_mag;
                st_d.dvs  = b_mag;
            end
        end else if (st_q.busy) begin
            st_d.part = part_nx;
            st_d.qacc = qacc_nx;
            st_d.cnt  = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(W-1)) begin
                st_d.busy  = 1'b0;
                st_d.done  = 1'b1;
                st_d.q_out = st_q.neg_q ? -qacc_nx : qacc_nx;
                st_d.r_out = st_q.neg_r ? -part_nx : part_nx;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign quo  = st_q.q_out;
    assign rem  = st_q.r_out;

    // R7
    udiv_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && !st_q.sgn && st_q.b_in != '0) |->
        ((st_q.q_out * st_q.b_in + st_q.r_out == st_q.a_in) && (st_q.r_out < st_q.b_in)));

    // R8
    zero_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.done && st_q.b_in == '0) |-> (st_q.q_out == '0 && st_q.r_out == st_q.a_in));

    // R13
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
endmodule

// File: rtl/bcalu_unit.sv
module bcalu_unit
    import bcalu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [15:0]      offset,
    input  logic [IMM_W-1:0] imm,
    input  logic [XLEN-1:0]  dst_val,
    input  logic [XLEN-1:0]  src_val,
    output logic             done,
    output logic [XLEN-1:0]  result,
    output logic             wr_en,
    output logic             illegal
);
    typedef struct packed {
        logic            busy;
        logic            done;
        logic            wr_en;
        logic            illegal;
        logic            wide;
        logic            want_rem;
        logic [XLEN-1:0] result;
    } top_st_t;

    top_st_t         st_d, st_q;
    dec_t            dec;
    logic [XLEN-1:0] exec_res;
    logic [XLEN-1:0] div_a, div_b;
    logic [XLEN-1:0] div_q, div_r, div_sel;
    logic            div_start, div_done;
    logic [XLEN-1:0] src_opnd;

    bcalu_decode u_decode (
        .opcode (opcode),
        .offset (offset),
        .imm    (imm),
        .dec_o  (dec)
    );

    bcalu_exec u_exec (
        .op      (dec.op),
        .wide    (dec.wide),
        .use_reg (dec.use_reg),
        .ext     (dec.ext),
        .swp     (dec.swp),
        .imm     (imm),
        .dst_val (dst_val),
        .src_val (src_val),
        .result  (exec_res)
    );

    assign src_opnd = dec.use_reg ? src_val : {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};

    always_comb begin
        if (dec.wide) begin
            div_a = dst_val;
            div_b = src_opnd;
        end else if (dec.signed_div) begin
            div_a = {{(XLEN-HALF){dst_val[HALF-1]}}, dst_val[HALF-1:0]};
            div_b = {{(XLEN-HALF){src_opnd[HALF-1]}}, src_opnd[HALF-1:0]};
        end else begin
            div_a = {{(XLEN-HALF){1'b0}}, dst_val[HALF-1:0]};
            div_b = {{(XLEN-HALF){1'b0}}, src_opnd[HALF-1:0]};
        end
    end

    bcalu_divider #(.W(XLEN)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .sgn      (dec.signed_div),
        .dividend (div_a),
        .divisor  (div_b),
        .done     (div_done),
        .quo      (div_q),
        .rem      (div_r)
    );

    always_comb begin
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.wr_en   = 1'b0;
        st_d.illegal = 1'b0;
        div_start    = 1'b0;
        div_sel      = st_q.want_rem ? div_r : div_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.wide = dec.wide;
                if (!dec.legal) begin
                    st_d.done    = 1'b1;
                    st_d.illegal = 1'b1;
                    st_d.result  = '0;
                end else if (dec.is_div) begin
                    div_start     = 1'b1;
                    st_d.busy     = 1'b1;
                    st_d.want_rem = dec.want_rem;
                end else begin
                    st_d.done   = 1'b1;
                    st_d.wr_en  = 1'b1;
                    st_d.result = exec_res;
                end
            end
        end else if (div_done) begin
            st_d.busy   = 1'b0;
            st_d.done   = 1'b1;
            st_d.wr_en  = 1'b1;
            st_d.result = st_q.wide ? div_sel : {{(XLEN-HALF){1'b0}}, div_sel[HALF-1:0]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done    = st_q.done;
    assign result  = st_q.result;
    assign wr_en   = st_q.wr_en;
    assign illegal = st_q.illegal;

    // R12
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !wr_en && result == '0));

    // R13
    write_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> done);

    // R4
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !st_q.wide) |-> (result[XLEN-1:HALF] == '0));

    // R13
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && start && !div_done) |=> (st_q.busy && !done));
endmodule

// File: tb/bcalu_unit_bench.sv
`timescale 1ns/1ps
module bcalu_unit_bench;
    localparam int DIV_LAT  = 66;
    localparam int WD_LIMIT = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] offset = '0;
    logic [31:0] imm = '0;
    logic [63:0] dst_val = '0;
    logic [63:0] src_val = '0;
    logic        done, wr_en, illegal;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    bcalu_unit u_bcalu_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .offset(offset), .imm(imm), .dst_val(dst_val), .src_val(src_val),
        .done(done), .result(result), .wr_en(wr_en), .illegal(illegal)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL R13 watchdog cycles=%0d expected < %0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h op=%h off=%0d imm=%h d=%h s=%h",
                     tag, act, exp, opcode, offset, imm, dst_val, src_val);
        end
    endtask

    function automatic void model(input logic [7:0] op, input logic [15:0] off,
                                  input logic [31:0] im, input logic [63:0] d,
                                  input logic [63:0] sreg, output logic [63:0] exp,
                                  output logic ill, output int lat, output string tag);
        logic [2:0]  cls;
        logic [3:0]  code;
        logic        sr, w64, zdiv;
        logic [63:0] s, r64;
        logic [31:0] a32, b32, r32;
        logic signed [63:0] sa, sb;
        logic signed [31:0] ta, tb;
        cls = op[2:0]; code = op[7:4]; sr = op[3];
        w64 = (cls == 3'h7);
        s   = sr ? sreg : {{32{im[31]}}, im};
        a32 = d[31:0]; b32 = s[31:0];
        r64 = '0; r32 = '0; ill = 1'b0; lat = 1; tag = "R2";
        sa = d; sb = s; ta = a32; tb = b32;
        case (code)
            4'h0: begin r64 = d + s; r32 = a32 + b32; ill = off != 0; end
            4'h1: begin r64 = d - s; r32 = a32 - b32; ill = off != 0; end
            4'h2: begin r64 = d * s; r32 = a32 * b32; ill = off != 0; end
            4'h4: begin r64 = d | s; r32 = a32 | b32; ill = off != 0; end
            4'h5: begin r64 = d & s; r32 = a32 & b32; ill = off != 0; end
            4'ha: begin r64 = d ^ s; r32 = a32 ^ b32; ill = off != 0; end
            4'h6: begin tag = "R3"; r64 = d << s[5:0]; r32 = a32 << b32[4:0]; ill = off != 0; end
            4'h7: begin tag = "R3"; r64 = d >> s[5:0]; r32 = a32 >> b32[4:0]; ill = off != 0; end
            4'hc: begin tag = "R3"; r64 = sa >>> s[5:0]; r32 = ta >>> b32[4:0]; ill = off != 0; end
            4'h8: begin tag = "R11"; r64 = -d; r32 = -a32; ill = (off != 0) || sr; end
            4'h3, 4'h9: begin
                tag = "R7";
                ill = off > 1;
                zdiv = w64 ? (s == 0) : (b32 == 0);
                lat = zdiv ? 2 : DIV_LAT;
                if (zdiv) begin
                    tag = "R8";
                    r64 = (code == 4'h3) ? 64'd0 : d;
                    r32 = (code == 4'h3) ? 32'd0 : a32;
                end else if (off == 0) begin
                    r64 = (code == 4'h3) ? d / s : d % s;
                    r32 = (code == 4'h3) ? a32 / b32 : a32 % b32;
                end else begin
                    if (w64 && sa == 64'sh8000000000000000 && sb == -64'sd1) begin
                        tag = "R9"; r64 = (code == 4'h3) ? d : 64'd0;
                    end else begin
                        r64 = (code == 4'h3) ? sa / sb : sa % sb;
                    end
                    if (!w64 && ta == 32'sh80000000 && tb == -32'sd1) begin
                        tag = "R9"; r32 = (code == 4'h3) ? a32 : 32'd0;
                    end else begin
                        r32 = (code == 4'h3) ? ta / tb : ta % tb;
                    end
                end
            end
            4'hb: begin
                tag = w64 ? "R5" : "R6";
                if (off == 0) begin r64 = s; r32 = b32; end
                else if (sr && off == 8) begin
                    r64 = {{56{s[7]}}, s[7:0]}; r32 = {{24{s[7]}}, s[7:0]};
                end else if (sr && off == 16) begin
                    r64 = {{48{s[15]}}, s[15:0]}; r32 = {{16{s[15]}}, s[15:0]};
                end else if (sr && off == 32 && w64) begin
                    r64 = {{32{s[31]}}, s[31:0]};
                end else ill = 1'b1;
            end
            4'hd: begin
                tag = "R10";
                ill = !w64 || sr || off != 0;
                if (im == 32'h10)      r64 = {48'd0, d[7:0], d[15:8]};
                else if (im == 32'h20) r64 = {32'd0, d[7:0], d[15:8], d[23:16], d[31:24]};
                else if (im == 32'h40) r64 = {d[7:0], d[15:8], d[23:16], d[31:24],
                                              d[39:32], d[47:40], d[55:48], d[63:56]};
                else ill = 1'b1;
            end
            default: ill = 1'b1;
        endcase
        if (cls != 3'h4 && cls != 3'h7) begin ill = 1'b1; tag = "R1"; end
        else if (ill) tag = "R12";
        if (ill) lat = 1;
        if (!ill && !w64) tag = {tag, "+R4"};
        exp = ill ? 64'd0 : (w64 ? r64 : {32'd0, r32});
    endfunction

    task automatic run_op(input logic [7:0] op, input logic [15:0] off,
                          input logic [31:0] im, input logic [63:0] d, input logic [63:0] s);
        logic [63:0] exp;
        logic        ill;
        int          lat;
        int          n;
        string       tag;
        model(op, off, im, d, s, exp, ill, lat, tag);
        @(negedge clk);
        opcode = op; offset = off; imm = im; dst_val = d; src_val = s; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        check({tag, " result"}, result, exp);
        check({tag, " illegal/wr_en"}, {62'd0, illegal, wr_en}, {62'd0, ill, !ill});
        check("R13 latency", 64'(n), 64'(lat));
    endtask

    logic [63:0] pa [5];
    logic [63:0] pb [5];
    int          offs [6];
    logic [31:0] imms [2];

    initial begin
        pa[0] = 64'h8000000000000000; pb[0] = 64'hffffffffffffffff;
        pa[1] = 64'h123456789abcdef0; pb[1] = 64'h0000000000000000;
        pa[2] = 64'hfedcba9876543210; pb[2] = 64'h00000000ffff80f7;
        pa[3] = 64'h0000000080000000; pb[3] = 64'h00000000ffffffff;
        pa[4] = 64'hfffffffffffffff9; pb[4] = 64'h0000000100000000;
        offs = '{0, 1, 8, 16, 32, 2};
        imms = '{32'hfffffff9, 32'h00000000};

        repeat (3) @(negedge clk);
        // R13: reset state
        check("R13 reset", {result[61:0], done, wr_en} | {63'd0, illegal}, 64'd0);
        rst_n = 1'b1;

        for (int p = 0; p < 5; p++)
            for (int o = 0; o < 256; o++)
                for (int f = 0; f < 6; f++)
                    for (int i = 0; i < 2; i++)
                        run_op(8'(o), 16'(offs[f]), imms[i], pa[p], pb[p]);

        // R10: byte swap widths, illegal widths and forms
        for (int p = 0; p < 5; p++) begin
            run_op(8'hd7, 16'd0, 32'h10, pa[p] ^ 64'h0102030405060708, pb[p]);
            run_op(8'hd7, 16'd0, 32'h20, pa[p] ^ 64'h0102030405060708, pb[p]);
            run_op(8'hd7, 16'd0, 32'h40, pa[p] ^ 64'h0102030405060708, pb[p]);
            run_op(8'hd7, 16'd0, 32'h30, pa[p], pb[p]);
            run_op(8'hdf, 16'd0, 32'h40, pa[p], pb[p]);
            run_op(8'hd4, 16'd0, 32'h20, pa[p], pb[p]);
        end
        // R9: signed overflow pair in both classes, register and immediate divisor
        run_op(8'h3f, 16'd1, 32'd0, 64'h8000000000000000, 64'hffffffffffffffff);
        run_op(8'h9f, 16'd1, 32'd0, 64'h8000000000000000, 64'hffffffffffffffff);
        run_op(8'h34, 16'd1, 32'hffffffff, 64'h0000000080000000, 64'd0);
        run_op(8'h94, 16'd1, 32'hffffffff, 64'h0000000080000000, 64'd0);

        // R13: start held during a divide is ignored
        begin
            logic [63:0] exp;
            logic        ill;
            int          lat;
            int          n;
            int          pulses;
            string       tag;
            model(8'h3f, 16'd0, 32'd0, 64'd1000003, 64'd7, exp, ill, lat, tag);
            @(negedge clk);
            opcode = 8'h3f; offset = 16'd0; imm = '0; dst_val = 64'd1000003; src_val = 64'd7;
            start = 1'b1;
            @(negedge clk);
            opcode = 8'h0f; dst_val = 64'd5; src_val = 64'd9;
            n = 1; pulses = 0;
            repeat (3) begin
                if (done) pulses++;
                @(negedge clk);
                n++;
            end
            start = 1'b0;
            while (!done && n < 200) begin
                @(negedge clk);
                n++;
            end
            check("R13 busy-ignore result", result, exp);
            check("R13 busy-ignore latency", 64'(n), 64'(DIV_LAT));
            repeat (80) begin
                if (done) pulses++;
                @(negedge clk);
            end
            check("R13 busy-ignore single done", 64'(pulses), 64'd1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule